// File: doc/BRIEF.md
# Vector Length State Sequencer

This block holds the 64-bit state word that steers a vector loop. The word packs the maximum vector length, the current vector length, the source and destination element positions, the sub-vector length and the position inside a sub-vector. It also holds five two-bit shape selectors with their five enable bits, a source sub-vector length, a flag that keeps the remap enables alive across instructions, and a flag that selects vertical-first stepping. Software changes the word in two ways. A set-length command clamps the requested vector length to the new maximum. A full-register write loads every field at once.

While code runs, the pipeline pulses an advance input each time a vector instruction retires. In horizontal mode that pulse walks the sub-vector position first, then the element positions. The element positions wrap after the last element, and a one-cycle loop-done pulse marks the wrap. In vertical-first mode the retire pulse leaves the positions alone, and only an explicit step request moves them. A command with an out-of-range value leaves the word unchanged and pulses an illegal-instruction flag. The selector and enable fields are also driven on their own ports for the remap logic outside the block.

Top module: `vl_state_seq`

## Requirements
- R1: After reset the state word is 64'h0200_0000_0000_0000, which means maximum length 1 and every other field zero. The illegal and loop-done outputs are low.
- R2: A legal set-length command changes the state word one cycle later. The maximum length becomes the requested maximum, the vector length becomes the smaller of the requested length and the requested maximum, and the source step, destination step and sub-vector step become zero.
- R3: A set-length command is illegal when the requested maximum is 0 or above 64, or the requested length is above 64. It pulses illegal high for one cycle and leaves the state word unchanged.
- R4: A legal full write stores each field at its position. Bit 63 is the MSB end of the layout: maxvl [63:57], vl [56:50], srcstep [49:43], dststep [42:36], subvl [35:34], svstep [33:32], selectors [31:22], enables [21:17], srcsubvl [16:15], reserved [14:2], persist [1], vfirst [0]. The reserved bits read back as zero. A vl above maxvl is stored as maxvl.
- R5: A full write is illegal when maxvl is 0 or above 64, vl is above 64, or srcstep or dststep is 64 or more. It pulses illegal for one cycle and leaves the state word unchanged.
- R6: A legal set-length command that changes the vector length or the maximum length clears the persist bit. One that changes neither leaves the bit as it is.
- R7: An advance pulse clears the five remap enables when persist is 0 and keeps them when persist is 1.
- R8: In horizontal mode (vfirst 0), each advance pulse increments svstep. When svstep equals the subvl code (the sub-vector length minus 1, with codes 0b00 to 0b11 for lengths 1 to 4), svstep wraps to 0 and srcstep and dststep each increment.
- R9: When an element wrap happens while dststep is the last element (vl-1), srcstep and dststep return to 0 and loop_done pulses for one cycle.
- R10: With vfirst 1, advance pulses leave all three steps unchanged. A step request advances them by the R8 and R9 rules.
- R11: With vl 0, advance pulses and step requests leave the steps unchanged and raise no loop_done.
- R12: A full write takes priority over a set-length command, and a set-length command takes priority over advance and step inputs in the same cycle. The inputs that lose have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_len_valid | input | 1 | Set-length command strobe |
| set_len_mvl | input | REQ_W | Requested maximum length |
| set_len_vl | input | REQ_W | Requested vector length |
| reg_wr_valid | input | 1 | Full state-word write strobe |
| reg_wr_data | input | 64 | State word to write |
| adv | input | 1 | Instruction-retire pulse |
| step_req | input | 1 | Explicit step request |
| state | output | 64 | Current state word |
| remap_sel | output | 10 | Five two-bit shape selectors |
| remap_en | output | 5 | Remap enable bits |
| illegal | output | 1 | Out-of-range command pulse |
| loop_done | output | 1 | Last-element wrap pulse |

## Verification
The assertions check on every cycle that the vector length never exceeds the maximum and that the maximum stays between 1 and 64. They also check that an illegal pulse always comes with an unchanged word, that loop_done only appears with all steps at zero, that vertical-first mode freezes the steps without a step request, and that a non-persistent retire clears the enables. Only the bench scenarios can show the exact clamped values, the field positions, the nested wrap order for each sub-vector length, the persist rule on set-length commands, and the input priority. For these a behavioural model is compared against the outputs every cycle.

// File: rtl/vl_state_seq.sv
module vl_state_seq #(
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_len_valid,
  input  logic [REQ_W-1:0] set_len_mvl,
  input  logic [REQ_W-1:0] set_len_vl,
  input  logic             reg_wr_valid,
  input  logic [63:0]      reg_wr_data,
  input  logic             adv,
  input  logic             step_req,
  output logic [63:0]      state,
  output logic [9:0]       remap_sel,
  output logic [4:0]       remap_en,
  output logic             illegal,
  output logic             loop_done
);
  localparam logic [REQ_W-1:0] LIM = REQ_W'(MAX_LEN);

  logic [6:0] mvl_q, vl_q, src_q, dst_q;
  logic [1:0] subvl_q, sv_q, ssub_q;
  logic [9:0] sel_q;
  logic [4:0] en_q;
  logic       pst_q, vf_q, ill_q, done_q;

  wire [6:0] w_mvl = reg_wr_data[63:57];
  wire [6:0] w_vl  = reg_wr_data[56:50];
  wire [6:0] w_src = reg_wr_data[49:43];
  wire [6:0] w_dst = reg_wr_data[42:36];

  logic unused_rsvd;
  assign unused_rsvd = ^reg_wr_data[14:2];

  wire wr_bad = (w_mvl == 7'd0) || (REQ_W'(w_mvl) > LIM) || (REQ_W'(w_vl) > LIM)
             || (REQ_W'(w_src) >= LIM) || (REQ_W'(w_dst) >= LIM);
  wire [6:0] w_vl_c = (w_vl > w_mvl) ? w_mvl : w_vl;

  wire set_bad = (set_len_mvl == '0) || (set_len_mvl > LIM) || (set_len_vl > LIM);
  wire [REQ_W-1:0] set_vl_c = (set_len_vl > set_len_mvl) ? set_len_mvl : set_len_vl;
  wire [6:0] set_mvl7 = set_len_mvl[6:0];
  wire [6:0] set_vl7  = set_vl_c[6:0];
  wire len_changed = (set_mvl7 != mvl_q) || (set_vl7 != vl_q);

  wire step_ev   = vf_q ? step_req : adv;
  wire do_step   = step_ev && (vl_q != 7'd0);
  wire sub_wrap  = sv_q >= subvl_q;
  wire elem_last = dst_q >= (vl_q - 7'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mvl_q   <= 7'd1;
      vl_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      subvl_q <= '0;
      sv_q    <= '0;
      sel_q   <= '0;
      en_q    <= '0;
      ssub_q  <= '0;
      pst_q   <= 1'b0;
      vf_q    <= 1'b0;
      ill_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ill_q  <= 1'b0;
      done_q <= 1'b0;
      if (reg_wr_valid) begin
        if (wr_bad) begin
          ill_q <= 1'b1;
        end else begin
          mvl_q   <= w_mvl;
          vl_q    <= w_vl_c;
          src_q   <= w_src;
          dst_q   <= w_dst;
          subvl_q <= reg_wr_data[35:34];
          sv_q    <= reg_wr_data[33:32];
          sel_q   <= reg_wr_data[31:22];
          en_q    <= reg_wr_data[21:17];
          ssub_q  <= reg_wr_data[16:15];
          pst_q   <= reg_wr_data[1];
          vf_q    <= reg_wr_data[0];
        end
      end else if (set_len_valid) begin
        if (set_bad) begin
          ill_q <= 1'b1;
        end else begin
          mvl_q <= set_mvl7;
          vl_q  <= set_vl7;
          src_q <= '0;
          dst_q <= '0;
          sv_q  <= '0;
          if (len_changed) pst_q <= 1'b0;
        end
      end else begin
        if (adv && !pst_q) en_q <= '0;
        if (do_step) begin
          if (!sub_wrap) begin
            sv_q <= sv_q + 2'd1;
          end else begin
            sv_q <= '0;
            if (elem_last) begin
              src_q  <= '0;
              dst_q  <= '0;
              done_q <= 1'b1;
            end else begin
              src_q <= src_q + 7'd1;
              dst_q <= dst_q + 7'd1;
            end
          end
        end
      end
    end
  end

  assign state = {mvl_q, vl_q, src_q, dst_q, subvl_q, sv_q, sel_q, en_q, ssub_q,
                  13'd0, pst_q, vf_q};
  assign remap_sel = sel_q;
  assign remap_en  = en_q;
  assign illegal   = ill_q;
  assign loop_done = done_q;
endmodule

// File: rtl/vl_state_seq_chk.sv
module vl_state_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        set_len_valid,
  input logic        reg_wr_valid,
  input logic        adv,
  input logic        step_req,
  input logic [63:0] state,
  input logic        illegal,
  input logic        loop_done
);
  wire [6:0]  c_mvl   = state[63:57];
  wire [6:0]  c_vl    = state[56:50];
  wire [15:0] c_steps = {state[49:36], state[33:32]};
  wire [4:0]  c_en    = state[21:17];
  wire        c_pst   = state[1];
  wire        c_vf    = state[0];

  p_vl_le_mvl_r2: assert property (@(posedge clk) disable iff (!rst_n) c_vl <= c_mvl);

  p_mvl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mvl >= 7'd1) && (c_mvl <= 7'd64));

  p_illegal_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> state == $past(state));

  p_done_zero_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> c_steps == 16'd0);

  p_vfirst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vf && !step_req && !reg_wr_valid && !set_len_valid) |=> $stable(c_steps));

  p_enable_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !c_pst && !reg_wr_valid && !set_len_valid) |=> c_en == 5'd0);

  p_done_needs_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> $past(c_vl) != 7'd0);
endmodule

bind vl_state_seq vl_state_seq_chk u_chk (.*);

// File: tb/sim_vl_state_seq.sv
module sim_vl_state_seq;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_len_valid = 1'b0;
  logic [7:0]  set_len_mvl = '0;
  logic [7:0]  set_len_vl = '0;
  logic        reg_wr_valid = 1'b0;
  logic [63:0] reg_wr_data = '0;
  logic        adv = 1'b0;
  logic        step_req = 1'b0;
  logic [63:0] state;
  logic [9:0]  remap_sel;
  logic [4:0]  remap_en;
  logic        illegal;
  logic        loop_done;

  vl_state_seq u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit finished = 0;

  int m_mvl, m_vl, m_src, m_dst, m_subvl, m_sv, m_sel, m_en, m_ssub, m_pst, m_vf;
  int m_ill, m_done;

  function automatic logic [63:0] mk(int mv, int v, int s, int d, int sb, int sv,
                                     int sel, int en, int ss, int p, int vf);
    logic [63:0] r;
    r = (64'(mv) << 57) | (64'(v) << 50) | (64'(s) << 43) | (64'(d) << 36)
      | (64'(sb) << 34) | (64'(sv) << 32) | (64'(sel) << 22) | (64'(en) << 17)
      | (64'(ss) << 15) | (64'(p) << 1) | 64'(vf);
    return r;
  endfunction

  function automatic logic [63:0] expect_word();
    return mk(m_mvl, m_vl, m_src, m_dst, m_subvl, m_sv, m_sel, m_en, m_ssub, m_pst, m_vf);
  endfunction

  task automatic model_reset();
    m_mvl = 1; m_vl = 0; m_src = 0; m_dst = 0; m_subvl = 0; m_sv = 0;
    m_sel = 0; m_en = 0; m_ssub = 0; m_pst = 0; m_vf = 0; m_ill = 0; m_done = 0;
  endtask

  task automatic model_step();
    int nm, nv, ns, nd;
    m_ill = 0; m_done = 0;
    if (reg_wr_valid) begin
      nm = int'((reg_wr_data >> 57) & 64'h7F);
      nv = int'((reg_wr_data >> 50) & 64'h7F);
      ns = int'((reg_wr_data >> 43) & 64'h7F);
      nd = int'((reg_wr_data >> 36) & 64'h7F);
      if (nm < 1 || nm > 64 || nv > 64 || ns > 63 || nd > 63) m_ill = 1;
      else begin
        m_mvl = nm; m_vl = (nv < nm) ? nv : nm; m_src = ns; m_dst = nd;
        m_subvl = int'((reg_wr_data >> 34) & 64'h3);
        m_sv    = int'((reg_wr_data >> 32) & 64'h3);
        m_sel   = int'((reg_wr_data >> 22) & 64'h3FF);
        m_en    = int'((reg_wr_data >> 17) & 64'h1F);
        m_ssub  = int'((reg_wr_data >> 15) & 64'h3);
        m_pst   = int'((reg_wr_data >> 1) & 64'h1);
        m_vf    = int'(reg_wr_data & 64'h1);
      end
    end else if (set_len_valid) begin
      nm = int'(set_len_mvl); nv = int'(set_len_vl);
      if (nm < 1 || nm > 64 || nv > 64) m_ill = 1;
      else begin
        if (nv > nm) nv = nm;
        if (nm != m_mvl || nv != m_vl) m_pst = 0;
        m_mvl = nm; m_vl = nv; m_src = 0; m_dst = 0; m_sv = 0;
      end
    end else begin
      if (adv && m_pst == 0) m_en = 0;
      if ((m_vf != 0 ? step_req : adv) && m_vl > 0) begin
        m_sv = m_sv + 1;
        if (m_sv > m_subvl) begin
          m_sv = 0; m_src = m_src + 1; m_dst = m_dst + 1;
          if (m_dst >= m_vl) begin m_src = 0; m_dst = 0; m_done = 1; end
        end
      end
    end
  endtask

  task automatic compare();
    logic [63:0] ew;
    ew = expect_word();
    n_cmp++;
    if (state !== ew || illegal !== m_ill[0] || loop_done !== m_done[0]
        || remap_sel !== m_sel[9:0] || remap_en !== m_en[4:0]) begin
      n_bad++;
      $display("FAIL %s: state=%h ill=%b done=%b sel=%h en=%h expected state=%h ill=%b done=%b sel=%h en=%h",
               tag, state, illegal, loop_done, remap_sel, remap_en,
               ew, m_ill[0], m_done[0], m_sel[9:0], m_en[4:0]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [63:0] d);
    reg_wr_valid = 1'b1; reg_wr_data = d; tick(); reg_wr_valid = 1'b0;
  endtask

  task automatic setl(int mv, int v);
    set_len_valid = 1'b1; set_len_mvl = 8'(mv); set_len_vl = 8'(v); tick();
    set_len_valid = 1'b0;
  endtask

  task automatic advn(int n);
    for (int i = 0; i < n; i++) begin adv = 1'b1; tick(); end
    adv = 1'b0;
  endtask

  task automatic stepn(int n);
    for (int i = 0; i < n; i++) begin step_req = 1'b1; tick(); end
    step_req = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    tag = "R1"; tick(); tick();
    rst_n = 1'b1;
    tick();

    tag = "R2"; setl(8, 5); setl(8, 20); setl(64, 64); tick();
    tag = "R3"; setl(0, 3); setl(65, 3); setl(10, 65); tick();

    tag = "R4"; wr(mk(10, 12, 3, 4, 2, 1, 10'h2A5, 5'h15, 1, 0, 0) | 64'h7FFC); tick();
    wr(mk(64, 64, 63, 63, 3, 3, 10'h3FF, 5'h1F, 3, 1, 0));
    tag = "R5"; wr(mk(8, 4, 64, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(mk(8, 4, 0, 64, 0, 0, 0, 0, 0, 0, 0));
    wr(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(mk(70, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(mk(64, 65, 0, 0, 0, 0, 0, 0, 0, 0, 0));

    tag = "R6"; wr(mk(16, 9, 0, 0, 0, 0, 10'h1C3, 5'h1F, 0, 1, 0));
    setl(16, 9); setl(16, 30); wr(mk(16, 9, 0, 0, 0, 0, 0, 5'h1F, 0, 1, 0));
    setl(20, 9);

    tag = "R7"; wr(mk(8, 4, 0, 0, 0, 0, 10'h0F0, 5'h0B, 0, 1, 0));
    advn(2); wr(mk(8, 4, 0, 0, 0, 0, 10'h0F0, 5'h0B, 0, 0, 0)); advn(1); tick();

    tag = "R8"; wr(mk(4, 3, 0, 0, 1, 0, 0, 0, 0, 0, 0)); advn(3);
    tag = "R9"; advn(3); tick(); wr(mk(8, 2, 0, 0, 3, 0, 0, 0, 0, 0, 0)); advn(9);
    wr(mk(8, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0)); advn(3);

    tag = "R10"; wr(mk(8, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1)); advn(4);
    stepn(4); adv = 1'b1; step_req = 1'b1; tick(); adv = 1'b0; step_req = 1'b0;

    tag = "R11"; setl(5, 0); wr(mk(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0)); advn(3);
    wr(mk(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1)); stepn(2);

    tag = "R12"; wr(mk(8, 8, 0, 0, 0, 0, 0, 5'h07, 0, 0, 0));
    reg_wr_valid = 1'b1; reg_wr_data = mk(12, 6, 1, 1, 0, 0, 0, 5'h03, 0, 0, 0);
    set_len_valid = 1'b1; set_len_mvl = 8'd30; set_len_vl = 8'd2; adv = 1'b1;
    tick();
    reg_wr_valid = 1'b0;
    tick();
    set_len_valid = 1'b0; adv = 1'b0; tick();
    reg_wr_valid = 1'b1; reg_wr_data = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_len_valid = 1'b1; set_len_mvl = 8'd4; set_len_vl = 8'd4; tick();
    reg_wr_valid = 1'b0; set_len_valid = 1'b0; tick();

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule